// File: doc/BRIEF.md
# Burst-Capable Word-Lane Bus Slave

This block is the target side of a shared external bus that carries 64-bit data and uses 32-bit word addresses. A bus master presents an address together with a read strobe or one or both write strobes. The slave claims the access when chip-select is high and the top five address bits match its window. It then serves the access from a small internal memory of 64-bit locations. The two write strobes select the 32-bit lanes. The low strobe alone writes the low half, the high strobe alone writes the high half, and both together write the whole location.

The slave can stretch any access it claims by pulling its acknowledge low for a configured number of wait states. While the master holds the burst line, the slave keeps only the first address of the run. Each later transfer goes to an internal pointer that advances after every completed transfer, by one word for single-lane writes and by two words otherwise. The pointer wraps around the memory. The master holds its request until it sees acknowledge high, and must change or withdraw it in the cycle after completion.

Top module: `xbus_burst_slave`

## Requirements
- R1: The slave claims an access only when `sel` is high and `bus_addr[31:27]` equals `WIN_PAT` (default 5'b00110). Any other strobe activity leaves `bus_ack` high, starts no transfer and changes no memory.
- R2: A claimed access with `rd_strb` and no write strobe is a read. It returns the 64-bit location `word[IDX_W:1]` on `bus_rdata`, and this value is stable from the first cycle after the request is sampled until completion.
- R3: A write with only `wr_lo_strb` stores `bus_wdata[31:0]` into bits 31:0 of the location and leaves bits 63:32 unchanged.
- R4: A write with only `wr_hi_strb` stores `bus_wdata[63:32]` into bits 63:32 of the location and leaves bits 31:0 unchanged.
- R5: A write with both strobes stores all 64 bits of `bus_wdata`. The write data is taken at the completing clock edge.
- R6: After a claimed request is sampled, `bus_ack` is low for exactly `cfg_wait` cycles (0 to 7). It is then high for one cycle, and that cycle completes the transfer.
- R7: Whenever no transfer is in progress, `bus_ack` is high.
- R8: When `burst_strb` is held high across transfers, every transfer after the first ignores `bus_addr` and uses the internal pointer.
- R9: After each completed burst transfer the pointer advances by 1 word for a single-lane write, and by 2 words for a read or a long-word write.
- R10: The pointer wraps modulo the memory size of 2^(IDX_W+1) words.
- R11: A burst ends when `burst_strb` is low in an idle cycle or at completion, or when an unclaimed request is seen. The next transfer then uses `bus_addr`.
- R12: Reset clears any transfer in progress, the wait count, the burst state and `bus_rdata`, and leaves `bus_ack` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 32 | Word address from the master |
| bus_wdata | input | 64 | Write data, low lane in bits 31:0 |
| bus_rdata | output | 64 | Read data, held for the whole data phase |
| rd_strb | input | 1 | Read request |
| wr_lo_strb | input | 1 | Write strobe for the low 32-bit lane |
| wr_hi_strb | input | 1 | Write strobe for the high 32-bit lane |
| burst_strb | input | 1 | Master marks consecutive transfers |
| sel | input | 1 | Chip-select |
| bus_ack | output | 1 | Acknowledge; low means wait |
| cfg_wait | input | 3 | Number of wait states per transfer |

## Verification
A wrong wait counter shows up within the same transfer: the number of acknowledge-low cycles no longer matches `cfg_wait`. A wrong lane enable or location index stays hidden until a later read of that location returns a corrupted half. The bench therefore reads back every written location against a shadow copy. A stale or wrong burst pointer shows only when the following transfer of the run lands at the wrong location. The bench therefore gives later burst transfers deliberately misleading addresses and reads afterwards both the intended location and the one the address pointed at.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  localparam int WAIT_W = 3;

  typedef enum logic [1:0] {
    K_RD   = 2'd0,
    K_LO   = 2'd1,
    K_HI   = 2'd2,
    K_LONG = 2'd3
  } xfer_kind_e;

  // window compare on the top five address bits, gated by chip-select
  function automatic logic win_hit(input logic [31:0] a, input logic cs,
                                   input logic [4:0] pat);
    return cs && (a[31:27] == pat);
  endfunction

  // lane strobes decide the transfer kind; any write strobe wins over read
  function automatic xfer_kind_e classify(input logic lo, input logic hi);
    if (lo && hi) return K_LONG;
    else if (lo)  return K_LO;
    else if (hi)  return K_HI;
    else          return K_RD;
  endfunction

  // words the burst pointer moves after a completed transfer
  function automatic logic [1:0] step_words(input xfer_kind_e k);
    return (k == K_LO || k == K_HI) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/xbs_decode.sv
module xbs_decode
  import xbs_pkg::*;
#(
  parameter logic [4:0] WIN_PAT = 5'b00110
) (
  input  logic [31:0] addr,
  input  logic        cs,
  input  logic        rd,
  input  logic        wr_lo,
  input  logic        wr_hi,
  output logic        req_any,
  output logic        hit,
  output xfer_kind_e  kind
);
  always_comb begin
    req_any = rd | wr_lo | wr_hi;
    hit     = win_hit(addr, cs, WIN_PAT);
    kind    = classify(wr_lo, wr_hi);
  end
endmodule

// File: rtl/xbs_wait_timer.sv
module xbs_wait_timer
  import xbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              busy,
  output logic              done,
  output logic              ack
);
  logic [WAIT_W-1:0] cnt_q;
  logic              busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= wait_cfg;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    busy = busy_q;
    done = busy_q && (cnt_q == '0);
    ack  = !busy_q || (cnt_q == '0);
  end
endmodule

// File: rtl/xbs_addr_seq.sv
module xbs_addr_seq #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          accept,
  input  logic          complete,
  input  logic          miss,
  input  logic          burst_in,
  input  logic [AW-1:0] req_word,
  input  logic [1:0]    step,
  output logic [AW-1:0] sel_word,
  output logic [AW-1:0] cur_word,
  output logic          burst_act
);
  logic [AW-1:0] ptr_q, cur_q;
  logic [1:0]    stp_q;
  logic          act_q;

  always_comb begin
    sel_word  = (burst_in && act_q) ? ptr_q : req_word;
    cur_word  = cur_q;
    burst_act = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cur_q <= '0;
      stp_q <= '0;
      act_q <= 1'b0;
    end else if (idle) begin
      if (!burst_in || miss) act_q <= 1'b0;
      if (accept) begin
        cur_q <= sel_word;
        stp_q <= step;
      end
    end else if (complete) begin
      if (burst_in) begin
        act_q <= 1'b1;
        ptr_q <= cur_q + AW'(stp_q);
      end else begin
        act_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xbs_lane_mem.sv
module xbs_lane_mem #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we_lo,
  input  logic             we_hi,
  input  logic [IDX_W-1:0] wr_loc,
  input  logic [63:0]      wdata,
  input  logic [IDX_W-1:0] rd_loc,
  output logic [63:0]      rdata
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [31:0] store [DEPTH];
    logic        we;
    assign we = (g == 0) ? we_lo : we_hi;

    always_ff @(posedge clk) begin
      if (we) store[wr_loc] <= wdata[32*g +: 32];
    end

    assign rdata[32*g +: 32] = store[rd_loc];
  end
endmodule

// File: rtl/xbus_burst_slave.sv
module xbus_burst_slave
  import xbs_pkg::*;
#(
  parameter int         IDX_W   = 4,
  parameter logic [4:0] WIN_PAT = 5'b00110
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic [63:0] bus_wdata,
  output logic [63:0] bus_rdata,
  input  logic        rd_strb,
  input  logic        wr_lo_strb,
  input  logic        wr_hi_strb,
  input  logic        burst_strb,
  input  logic        sel,
  output logic        bus_ack,
  input  logic [2:0]  cfg_wait
);
  localparam int AW = IDX_W + 1;

  logic          req_any, hit;
  xfer_kind_e    kind_w, kind_q;
  logic          busy_w, done_w, accept_w, miss_w;
  logic          we_lo_w, we_hi_w, burst_act_w;
  logic [AW-1:0] sel_word, cur_word;
  logic [63:0]   mem_rd, rdata_q;

  xbs_decode #(.WIN_PAT(WIN_PAT)) u_dec (
    .addr(bus_addr), .cs(sel), .rd(rd_strb), .wr_lo(wr_lo_strb),
    .wr_hi(wr_hi_strb), .req_any(req_any), .hit(hit), .kind(kind_w)
  );

  assign accept_w = !busy_w && req_any && hit;
  assign miss_w   = !busy_w && req_any && !hit;

  xbs_wait_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept_w), .wait_cfg(cfg_wait),
    .busy(busy_w), .done(done_w), .ack(bus_ack)
  );

  xbs_addr_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .idle(!busy_w), .accept(accept_w),
    .complete(done_w), .miss(miss_w), .burst_in(burst_strb),
    .req_word(bus_addr[AW-1:0]), .step(step_words(kind_w)),
    .sel_word(sel_word), .cur_word(cur_word), .burst_act(burst_act_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_RD;
      rdata_q <= '0;
    end else if (accept_w) begin
      kind_q <= kind_w;
      if (kind_w == K_RD) rdata_q <= mem_rd;
    end
  end

  assign we_lo_w = done_w && (kind_q == K_LO || kind_q == K_LONG);
  assign we_hi_w = done_w && (kind_q == K_HI || kind_q == K_LONG);

  xbs_lane_mem #(.IDX_W(IDX_W)) u_mem (
    .clk(clk), .we_lo(we_lo_w), .we_hi(we_hi_w),
    .wr_loc(cur_word[AW-1:1]), .wdata(bus_wdata),
    .rd_loc(sel_word[AW-1:1]), .rdata(mem_rd)
  );

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/xbs_checker.sv
module xbs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       busy,
  input logic       done,
  input logic       accept,
  input logic       miss,
  input logic       we_lo,
  input logic       we_hi,
  input logic       burst_in,
  input logic       burst_act,
  input logic [2:0] cfg_wait
);
  logic [2:0] ck_wait;
  logic [3:0] ck_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_wait <= '0;
      ck_low  <= '0;
    end else if (accept) begin
      ck_wait <= cfg_wait;
      ck_low  <= '0;
    end else if (busy && !ack) begin
      ck_low <= ck_low + 1'b1;
    end
  end

  AST_ACK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ack); // R7
  AST_WAIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ck_low == {1'b0, ck_wait})); // R6
  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> !busy); // R1
  AST_WRITE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo || we_hi) |-> done); // R5
  AST_BURST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && burst_in) |=> burst_act); // R8
  AST_BURST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !burst_in) |=> !burst_act); // R11
endmodule

bind xbus_burst_slave xbs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ack(bus_ack), .busy(busy_w), .done(done_w),
  .accept(accept_w), .miss(miss_w), .we_lo(we_lo_w), .we_hi(we_hi_w),
  .burst_in(burst_strb), .burst_act(burst_act_w), .cfg_wait(cfg_wait)
);

// File: tb/sim_xbus_burst_slave.sv
module sim_xbus_burst_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        rd = 1'b0, wl = 1'b0, wh = 1'b0, bst = 1'b0, cs = 1'b0;
  logic        ack;
  logic [2:0]  cw = '0;

  int total = 0, fails = 0;
  bit done_flag = 0;
  logic [63:0] mdl [16];

  always #4 clk = ~clk;

  xbus_burst_slave u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .rd_strb(rd), .wr_lo_strb(wl), .wr_hi_strb(wh),
    .burst_strb(bst), .sel(cs), .bus_ack(ack), .cfg_wait(cw)
  );

  function automatic logic [31:0] wa(input int w);
    return {5'b00110, 27'(w)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic mdl_wr(input int loc, input logic [1:0] k, input logic [63:0] d);
    if (k == 2'd1 || k == 2'd3) mdl[loc][31:0]  = d[31:0];
    if (k == 2'd2 || k == 2'd3) mdl[loc][63:32] = d[63:32];
  endtask

  // kind: 0 read, 1 low lane, 2 high lane, 3 long word
  task automatic xfer(input logic [31:0] a, input logic [1:0] k, input logic [63:0] d,
                      input logic [2:0] w, output logic [63:0] rv);
    int lows;
    @(negedge clk);
    addr = a; rd = (k == 2'd0); wl = (k == 2'd1 || k == 2'd3);
    wh = (k == 2'd2 || k == 2'd3); wdata = d; cw = w; cs = 1'b1;
    @(posedge clk);
    lows = 0;
    forever begin
      @(negedge clk);
      if (ack === 1'b1 || lows > 20) break;
      lows++;
    end
    chk("R6 wait cycles", 64'(lows), 64'(w));
    rv = rdata;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0; wl = 1'b0; wh = 1'b0; addr = '0;
  endtask

  task automatic end_burst();
    bst = 1'b0;
    @(negedge clk);
  endtask

  // {word[4:0], kind[1:0], wait[2:0], data[63:0]}
  localparam logic [73:0] TBL [12] = '{
    {5'd0,  2'd3, 3'd0, 64'hA0A0_0001_B0B0_0002},
    {5'd2,  2'd1, 3'd1, 64'h1111_2222_3333_4444},
    {5'd3,  2'd2, 3'd2, 64'h5555_6666_7777_8888},
    {5'd2,  2'd0, 3'd0, 64'h0},
    {5'd0,  2'd0, 3'd3, 64'h0},
    {5'd30, 2'd3, 3'd7, 64'hCAFE_F00D_1234_5678},
    {5'd31, 2'd0, 3'd7, 64'h0},
    {5'd0,  2'd1, 3'd0, 64'h0000_0000_DEAD_BEEF},
    {5'd1,  2'd0, 3'd1, 64'h0},
    {5'd4,  2'd3, 3'd0, 64'h0404_0404_4040_4040},
    {5'd14, 2'd3, 3'd2, 64'h7777_0000_0000_7777},
    {5'd22, 2'd3, 3'd1, 64'h2222_BBBB_2222_BBBB}
  };

  task automatic rd_chk(input int word, input string req);
    logic [63:0] v;
    xfer(wa(word), 2'd0, 64'h0, 3'd0, v);
    chk(req, v, mdl[word >> 1]);
  endtask

  initial begin
    logic [63:0] v;
    // reset state (R12, R7)
    repeat (3) @(negedge clk);
    chk("R12 ack after reset", 64'(ack), 64'd1);
    chk("R12 rdata after reset", rdata, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 ack idle", 64'(ack), 64'd1);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < 12; i++) begin
      logic [4:0] w5; logic [1:0] k; logic [2:0] ws; logic [63:0] d;
      {w5, k, ws, d} = TBL[i];
      xfer(wa(int'(w5)), k, d, ws, v);
      if (k == 2'd0) chk("R2 R3 R4 R5 read back", v, mdl[w5 >> 1]);
      else mdl_wr(int'(w5 >> 1), k, d);
    end

    // R1 out of window and chip-select low
    @(negedge clk);
    addr = {5'b00111, 27'd4}; wl = 1'b1; wh = 1'b1; wdata = 64'hBAD0_BAD0_BAD0_BAD0; cs = 1'b1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); chk("R1 ack outside window", 64'(ack), 64'd1); end
    addr = wa(4); cs = 1'b0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); chk("R1 ack with sel low", 64'(ack), 64'd1); end
    wl = 1'b0; wh = 1'b0; cs = 1'b1; addr = '0;
    rd_chk(4, "R1 memory untouched");

    // R8 R9 long-word burst write with misleading addresses
    bst = 1'b1;
    xfer(wa(8), 2'd3, 64'hD000_0000_0000_000D, 3'd1, v); mdl_wr(4, 2'd3, 64'hD000_0000_0000_000D);
    xfer(wa(0), 2'd3, 64'hD111_1111_1111_111D, 3'd0, v); mdl_wr(5, 2'd3, 64'hD111_1111_1111_111D);
    xfer(wa(0), 2'd3, 64'hD222_2222_2222_222D, 3'd2, v); mdl_wr(6, 2'd3, 64'hD222_2222_2222_222D);
    end_burst();
    rd_chk(10, "R8 burst second location");
    rd_chk(12, "R9 burst third location");
    rd_chk(0, "R8 address ignored in burst");

    // R9 single-lane burst steps one word
    bst = 1'b1;
    xfer(wa(20), 2'd1, 64'h0000_0000_E000_000E, 3'd0, v); mdl_wr(10, 2'd1, 64'h0000_0000_E000_000E);
    xfer(wa(0),  2'd2, 64'hE111_111E_0000_0000, 3'd1, v); mdl_wr(10, 2'd2, 64'hE111_111E_0000_0000);
    xfer(wa(0),  2'd1, 64'h0000_0000_E222_222E, 3'd0, v); mdl_wr(11, 2'd1, 64'h0000_0000_E222_222E);
    end_burst();
    rd_chk(20, "R9 lanes of first location");
    rd_chk(22, "R9 low lane of next location");

    // R8 burst read
    bst = 1'b1;
    xfer(wa(8), 2'd0, 64'h0, 3'd0, v);  chk("R8 burst read first", v, mdl[4]);
    xfer(wa(30), 2'd0, 64'h0, 3'd1, v); chk("R8 burst read second", v, mdl[5]);
    xfer(wa(30), 2'd0, 64'h0, 3'd0, v); chk("R9 burst read third", v, mdl[6]);
    end_burst();

    // R10 wrap
    bst = 1'b1;
    xfer(wa(30), 2'd3, 64'hF000_0000_0000_000F, 3'd0, v); mdl_wr(15, 2'd3, 64'hF000_0000_0000_000F);
    xfer(wa(6),  2'd3, 64'hF111_1111_1111_111F, 3'd0, v); mdl_wr(0, 2'd3, 64'hF111_1111_1111_111F);
    end_burst();
    rd_chk(0, "R10 wrap to location 0");
    rd_chk(6, "R10 addressed location untouched");

    // R11 burst drop then fresh address
    bst = 1'b1;
    xfer(wa(12), 2'd3, 64'h6060_6060_6060_6060, 3'd0, v); mdl_wr(6, 2'd3, 64'h6060_6060_6060_6060);
    bst = 1'b0;
    xfer(wa(18), 2'd3, 64'h9090_9090_9090_9090, 3'd0, v); mdl_wr(9, 2'd3, 64'h9090_9090_9090_9090);
    rd_chk(18, "R11 fresh address used");
    rd_chk(14, "R11 pointer target untouched");

    // R12 reset during a data phase
    xfer(wa(4), 2'd0, 64'h0, 3'd0, v);
    @(negedge clk);
    addr = wa(0); rd = 1'b1; cw = 3'd7;
    @(negedge clk); @(negedge clk);
    chk("R6 ack low in wait", 64'(ack), 64'd0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R12 ack after mid reset", 64'(ack), 64'd1);
    chk("R12 rdata after mid reset", rdata, 64'h0);
    rd = 1'b0; addr = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 ack idle after reset", 64'(ack), 64'd1);

    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule